// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a cycle-level functional model of a 16-bit-wide asynchronous static memory. A fast simulation clock samples the control pins. The pins are an active-low chip select, write enable, output enable and two active-low byte-lane enables. The block then settles each sample into one of four operating modes: standby, output-disable, read or write. The bidirectional data bus is split into a data-in bus, a data-out bus and one output-enable bit per byte lane. A surrounding bench or pad wrapper turns these into a tri-state bus.

The memory keeps the last data, address and lane mask seen while the write condition holds. It stores them in the first sampled cycle after write enable or chip select returns high, whichever comes first. A read drives only the lanes whose enables are low. A lane that is not driven reports zero on its data-out slice with its output-enable bit low. The nominal part has 262,144 words and 18 address lines. Storage depth is a parameter, so a simulation can use a small array. Address bits above the array index are ignored.

A mode state machine has four states: STANDBY, OUTDIS, READ and WRITE. It re-evaluates its next state from the pins every cycle. There are two named transitions. "Enter write" is any state moving to WRITE. "End write" is WRITE moving to any other state, and it fires the commit. All other moves follow the pin decode directly. The block also raises a one-cycle flag when the address moves while chip select and write enable are both low.

Top module: `sram_lane_model`

## Requirements
- R1: The address port is AW bits (default 18). Storage holds DEPTH words (default 1024, a power of two), indexed by the low log2(DEPTH) address bits. With the defaults, addresses 0x010 and 0x410 reach the same word.
- R2: When chip select is high, or both lane enables are high, the mode is standby. One cycle after such a sample, both lane output-enable bits are 0 and data-out is 0.
- R3: With chip select and output enable low and write enable high, the mode is read. One cycle later, lane_oe[0] equals the inverse of the lower enable and lane_oe[1] equals the inverse of the upper enable. dout[7:0] carries bits 7:0 of the addressed word and dout[15:8] carries bits 15:8, each only on an enabled lane.
- R4: With chip select low and both write enable and output enable high, the mode is output-disable. Both lanes are off one cycle later.
- R5: With chip select and write enable low and at least one lane enable low, the mode is write. Both lanes are off one cycle later, whatever output enable is.
- R6: A write is stored in the first sampled cycle that leaves the write mode. It uses the address, data and lane enables of the last write-mode cycle, so data applied earlier in the same write is overwritten.
- R7: A write with one lane enabled leaves the other byte of the word unchanged. The lower enable guards bits 7:0 and the upper enable guards bits 15:8.
- R8: A write ended by chip select rising, with write enable still low, is stored exactly like one ended by write enable.
- R9: A read sampled in the same cycle that ends a write to the same word returns the newly written data.
- R10: If the address differs between two consecutive samples that both have chip select and write enable low, addr_viol is 1 in the following cycle and 0 otherwise.
- R11: While reset is low, lane_oe, dout and addr_viol are 0. A write still open when reset is asserted is discarded.
- R12: A lane that is not driven presents 0 on its slice of dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lb_n | input | 1 | Active-low enable, bits 7:0 |
| ub_n | input | 1 | Active-low enable, bits 15:8 |
| din | input | 2*LANE_W | Write data from the bus |
| dout | output | 2*LANE_W | Read data toward the bus |
| lane_oe | output | 2 | Per-lane driver enable, bit 0 lower lane |
| addr_viol | output | 1 | Address moved during a write-low window |

## Verification
The hardest case to reach is the cycle where a write ends and a read of the same word is sampled at once. Write enable must rise while output enable is already low and chip select stays low. The bench forces this by raising write enable on a sample where output enable is already low, which triggers the commit and the forwarded read in one edge. A second hard case is reset arriving while a write is open. The bench asserts reset in the middle of a write and reads the word afterwards to show that the old contents survived.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY,
        MODE_OUTDIS,
        MODE_READ,
        MODE_WRITE
    } sram_mode_e;

    localparam int LANES = 2;

    // Priority: deselect, then both lanes off, then write, then read.
    function automatic sram_mode_e decode_mode(
        input logic             cs_n,
        input logic             we_n,
        input logic             oe_n,
        input logic [LANES-1:0] be_n
    );
        if (cs_n)             return MODE_STANDBY;
        else if (&be_n)       return MODE_STANDBY;
        else if (!we_n)       return MODE_WRITE;
        else if (!oe_n)       return MODE_READ;
        else                  return MODE_OUTDIS;
    endfunction

endpackage

// File: rtl/sram_mode_ctrl.sv
module sram_mode_ctrl
    import sram_lane_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] be_n,
    output sram_mode_e       mode_nxt,
    output logic             capture,
    output logic             commit
);

    sram_mode_e mode_q;

    assign mode_nxt = decode_mode(cs_n, we_n, oe_n, be_n);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_STANDBY;
        else        mode_q <= mode_nxt;
    end

    // transition outputs: enter write latches, end write commits
    always_comb begin
        capture = 1'b0;
        commit  = 1'b0;
        unique case (mode_q)
            MODE_WRITE: begin
                capture = (mode_nxt == MODE_WRITE);
                commit  = (mode_nxt != MODE_WRITE);
            end
            MODE_STANDBY, MODE_OUTDIS, MODE_READ: begin
                capture = (mode_nxt == MODE_WRITE);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_write_latch.sv
module sram_write_latch #(
    parameter int AW     = 18,
    parameter int IW     = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    input  logic [LANES-1:0] be_n,
    input  logic             cs_n,
    input  logic             we_n,
    output logic [IW-1:0]    wr_idx,
    output logic [DW-1:0]    wr_data,
    output logic [LANES-1:0] wr_mask,
    output logic             addr_viol
);

    logic          low_win;
    logic          low_win_q;
    logic [AW-1:0] addr_q;

    assign low_win = !cs_n && !we_n;

    // hold the last write-mode sample until the commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx  <= '0;
            wr_data <= '0;
            wr_mask <= '0;
        end else if (capture) begin
            wr_idx  <= addr[IW-1:0];
            wr_data <= din;
            wr_mask <= ~be_n;
        end
    end

    // address-stability guard over the write-low window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_win_q <= 1'b0;
            addr_q    <= '0;
            addr_viol <= 1'b0;
        end else begin
            low_win_q <= low_win;
            addr_q    <= addr;
            addr_viol <= low_win && low_win_q && (addr != addr_q);
        end
    end

endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int DEPTH  = 1024,
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int IW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             commit,
    input  logic [IW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [LANES-1:0] wr_mask,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] raw;
    logic          hit;

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_mask[l]) mem[wr_idx][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
    end

    assign raw = mem[rd_idx];
    assign hit = commit && (wr_idx == rd_idx);

    // forward committing lanes to a read of the same word
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign rd_data[l*LANE_W +: LANE_W] = (hit && wr_mask[l]) ?
                                             wr_data[l*LANE_W +: LANE_W] :
                                             raw[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                cs_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                lb_n,
    input  logic                ub_n,
    input  logic [2*LANE_W-1:0] din,
    output logic [2*LANE_W-1:0] dout,
    output logic [1:0]          lane_oe,
    output logic                addr_viol
);

    localparam int IW = $clog2(DEPTH);
    localparam int DW = LANES * LANE_W;

    logic [LANES-1:0] be_n;
    sram_mode_e       mode_nxt;
    logic             capture;
    logic             commit;
    logic [IW-1:0]    wr_idx;
    logic [DW-1:0]    wr_data;
    logic [LANES-1:0] wr_mask;
    logic [DW-1:0]    rd_data;
    logic [LANES-1:0] oe_nxt;
    logic [DW-1:0]    dout_nxt;

    assign be_n = {ub_n, lb_n};

    sram_mode_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .be_n     (be_n),
        .mode_nxt (mode_nxt),
        .capture  (capture),
        .commit   (commit)
    );

    sram_write_latch #(.AW(AW), .IW(IW), .LANES(LANES), .LANE_W(LANE_W)) u_wlat (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .addr      (addr),
        .din       (din),
        .be_n      (be_n),
        .cs_n      (cs_n),
        .we_n      (we_n),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .addr_viol (addr_viol)
    );

    sram_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .commit  (commit && rst_n),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .rd_idx  (addr[IW-1:0]),
        .rd_data (rd_data)
    );

    // each lane drives on its own enable, zero when idle
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign oe_nxt[l] = (mode_nxt == MODE_READ) && !be_n[l];
        assign dout_nxt[l*LANE_W +: LANE_W] = oe_nxt[l] ? rd_data[l*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_oe <= '0;
            dout    <= '0;
        end else begin
            lane_oe <= oe_nxt;
            dout    <= dout_nxt;
        end
    end

endmodule

// File: rtl/sram_lane_model_chk.sv
module sram_lane_model_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       lb_n,
    input logic       ub_n,
    input logic [1:0] lane_oe,
    input logic       addr_viol
);

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (lb_n && ub_n)) |=> (lane_oe == 2'b00));

    // R4
    outdis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && oe_n) |=> (lane_oe == 2'b00));

    // R5
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> (lane_oe == 2'b00));

    // R3
    read_low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n && !lb_n) |=> lane_oe[0]);

    // R3
    read_high_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n && !ub_n) |=> lane_oe[1]);

    // R3
    lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_n && !ub_n) |=> !lane_oe[0]);

    // R10
    viol_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_viol |-> $past(!cs_n && !we_n));

endmodule

bind sram_lane_model sram_lane_model_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .lb_n      (lb_n),
    .ub_n      (ub_n),
    .lane_oe   (lane_oe),
    .addr_viol (addr_viol)
);

// File: tb/sram_lane_model_test.sv
`timescale 1ns/1ps
module sram_lane_model_test;

    localparam int AW    = 18;
    localparam int DEPTH = 1024;
    localparam int IW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    lane_oe;
    logic          addr_viol;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [1:0]  oe;
        logic [15:0] data;
        logic        viol;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // bench reference state
    logic [15:0]   ref_mem [DEPTH];
    logic          w_open = 1'b0;
    logic [IW-1:0] w_idx;
    logic [15:0]   w_data;
    logic [1:0]    w_mask;
    logic          prev_low = 1'b0;
    logic [AW-1:0] prev_a = '0;

    always #2.5 clk = ~clk;

    sram_lane_model #(.AW(AW), .DEPTH(DEPTH), .LANE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .din(din), .dout(dout),
        .lane_oe(lane_oe), .addr_viol(addr_viol)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // driver: apply one sample of pins and queue the expected response
    task automatic cyc(input logic [AW-1:0] a, input logic c, input logic w,
                       input logic o, input logic l, input logic u,
                       input logic [15:0] d, input string tag);
        exp_t e;
        logic [1:0]  en;
        logic        is_write, is_read, low;
        @(negedge clk);
        addr = a; cs_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; din = d;
        is_write = !c && !(l && u) && !w;
        is_read  = !c && !(l && u) && w && !o;
        low      = !c && !w;
        if (w_open && !is_write) begin
            if (w_mask[0]) ref_mem[w_idx][7:0]  = w_data[7:0];
            if (w_mask[1]) ref_mem[w_idx][15:8] = w_data[15:8];
        end
        w_open = is_write;
        if (is_write) begin
            w_idx = a[IW-1:0]; w_data = d; w_mask = {!u, !l};
        end
        en = is_read ? {!u, !l} : 2'b00;
        e.oe   = en;
        e.data = {en[1] ? ref_mem[a[IW-1:0]][15:8] : 8'h00,
                  en[0] ? ref_mem[a[IW-1:0]][7:0]  : 8'h00};
        e.viol = prev_low && low && (a != prev_a);
        e.tag  = tag;
        prev_low = low;
        prev_a   = a;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        cyc('0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, tag);
    endtask

    task automatic do_reset();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        w_open = 1'b0; prev_low = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (lane_oe !== 2'b00 || dout !== 16'h0000 || addr_viol !== 1'b0) begin
            fails++;
            $display("FAIL R11: reset outputs oe=%b dout=%h viol=%b, expected 00/0000/0",
                     lane_oe, dout, addr_viol);
        end
        rst_n = 1'b1;
    endtask

    // monitor: compare each queued item after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (lane_oe !== e.oe || dout !== e.data || addr_viol !== e.viol) begin
                    fails++;
                    $display("FAIL %s: oe=%b dout=%h viol=%b, expected oe=%b dout=%h viol=%b",
                             e.tag, lane_oe, dout, addr_viol, e.oe, e.data, e.viol);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected finish");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R2 deselected with output enable low
        cyc(18'h010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R2 cs high");
        // R5 full write, lanes off even with oe low
        cyc(18'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, "R5 write");
        cyc(18'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, "R5 write hold");
        idle("R6 we end");
        // R3 reads, R12 idle lane zero
        cyc(18'h010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R3 read both");
        cyc(18'h010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0, "R3 R12 read low");
        cyc(18'h010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R3 R12 read high");
        // R2 both lanes off with chip selected
        cyc(18'h010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R2 lanes off");
        // R4 output disable
        cyc(18'h010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, "R4 outdis");
        // R7 upper-lane write only
        cyc(18'h010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hABCD, "R7 upper write");
        idle("R7 end");
        cyc(18'h010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R7 readback");
        // R8 chip-select terminated write
        cyc(18'h020, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h5A5A, "R8 write");
        cyc(18'h020, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, "R8 cs rise");
        cyc(18'h020, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R8 readback");
        // R6 only the last write-mode data is stored
        cyc(18'h030, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1111, "R6 first data");
        cyc(18'h030, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h2222, "R6 last data");
        idle("R6 end");
        cyc(18'h030, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R6 readback");
        // R9 read sampled on the terminating cycle
        cyc(18'h040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF, "R9 write");
        cyc(18'h040, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R9 forward");
        // R10 address moves in the write-low window
        cyc(18'h050, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hC0DE, "R10 write");
        cyc(18'h051, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hC0DF, "R10 violation");
        cyc(18'h051, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hC0DF, "R10 steady");
        idle("R10 end");
        cyc(18'h051, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R10 readback");
        // R1 upper address bits alias
        cyc(18'h410, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R1 alias");
        // R11 open write dropped by reset
        cyc(18'h060, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0001, "R11 setup");
        idle("R11 setup end");
        cyc(18'h060, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h7777, "R11 open write");
        do_reset();
        cyc(18'h060, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R11 old data kept");
        idle("final idle");
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        summary();
        $finish;
    end

endmodule